// File: doc/BRIEF.md
# Game Button Input Conditioner

This block turns seven raw, asynchronous game-controller buttons (left, right, soft drop, hard drop, pause, rotate, hold) into clean action pulses for a falling-block puzzle game. Every raw input gets its own two-flop synchronizer and a stability filter. Each press of a filtered button gives exactly one pulse, one clock wide, on that action's output. Releasing a button never gives a pulse.

Soft drop is the only action that repeats while held. After an initial delay it pulses at a fixed interval until released. A separate level output reports whether soft drop is currently held. While the menu-navigation gate input is high, soft drop does not repeat, so each menu step needs a fresh press. Pause can come from the external pause button or the onboard pause button. A parameter chooses whether soft drop is taken from the external button or the onboard one.

Top module: `game_btn_cond`

## Requirements
- R1: Each of the seven actions drives only its own output: left_o, right_o, soft_o, hard_o, pause_o, rotate_o, hold_o. A press on one button gives no pulse on any other output.
- R2: A raw input change that lasts fewer than DEB_CYCLES consecutive cycles has no effect. A change that stays stable for DEB_CYCLES cycles takes effect about 2 + DEB_CYCLES cycles after the input settles.
- R3: One press, including a press whose edges bounce, gives exactly one pulse on its output, and that pulse is one clock cycle wide.
- R4: While the soft-drop button stays held, soft_o pulses again RPT_DELAY cycles after the press and then every RPT_INTERVAL cycles until release. No other button repeats, however long it is held.
- R5: Releasing a button gives no pulse. Pressing the same button again after release gives a new pulse.
- R6: While nav_gate_i is high, soft_o gives no repeat pulses. A fresh press still gives its single pulse.
- R7: pause_o pulses on a press of either pause_i or pause_board_i.
- R8: soft_held_o is high while the filtered soft-drop button is held, and low otherwise.
- R9: While rst_ni is low, every output is 0, and all filter and repeat state is cleared.
- R10: With SOFT_ONBOARD = 0, soft drop is taken from soft_i and soft_board_i is ignored. With SOFT_ONBOARD = 1, soft drop is taken from soft_board_i and soft_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| left_i | input | 1 | Raw left button |
| right_i | input | 1 | Raw right button |
| soft_i | input | 1 | Raw external soft-drop button |
| hard_i | input | 1 | Raw hard-drop button |
| pause_i | input | 1 | Raw external pause button |
| rotate_i | input | 1 | Raw rotate button |
| hold_i | input | 1 | Raw hold button |
| pause_board_i | input | 1 | Raw onboard pause button |
| soft_board_i | input | 1 | Raw onboard soft-drop button |
| nav_gate_i | input | 1 | High while menus are active; stops soft-drop repeat |
| left_o | output | 1 | Left action pulse |
| right_o | output | 1 | Right action pulse |
| soft_o | output | 1 | Soft-drop pulse (press and repeats) |
| hard_o | output | 1 | Hard-drop pulse |
| pause_o | output | 1 | Pause pulse |
| rotate_o | output | 1 | Rotate pulse |
| hold_o | output | 1 | Hold pulse |
| soft_held_o | output | 1 | Filtered soft-drop level |

## Verification
A filter counter that is not cleared by a bounce shows up within one press: a glitch shorter than the filter window then gets through as a stray pulse, or a bouncy press gives two pulses instead of one. A stuck edge-history flop shows up on the next press, as a missing pulse or a pulse wider than one cycle. A repeat timer with a wrong phase or a wrong terminal count changes the number of soft_o pulses within one long hold. A gate that does not work shows the same effect while nav_gate_i is high. A wrong source select or a wrong pause merge is seen at the very first press of the onboard button.

// File: rtl/game_btn_pkg.sv
`timescale 1ns/1ps
package game_btn_pkg;
  localparam int unsigned N_ACT = 7;
  localparam int unsigned N_RAW = 9;
  // action channel order, also raw index of the external buttons
  localparam int unsigned CH_LEFT   = 0;
  localparam int unsigned CH_RIGHT  = 1;
  localparam int unsigned CH_SOFT   = 2;
  localparam int unsigned CH_HARD   = 3;
  localparam int unsigned CH_PAUSE  = 4;
  localparam int unsigned CH_ROTATE = 5;
  localparam int unsigned CH_HOLD   = 6;
  // extra onboard raw inputs
  localparam int unsigned RAW_PAUSE_BOARD = 7;
  localparam int unsigned RAW_SOFT_BOARD  = 8;
endpackage

// File: rtl/btn_sync.sv
`timescale 1ns/1ps
module btn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/btn_debounce.sv
`timescale 1ns/1ps
module btn_debounce #(
  parameter int unsigned CYCLES = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic lvl_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (sync_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(CYCLES - 1)) begin
      cnt_q <= '0;
      lvl_q <= sync_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;

  // R2: the filtered level only ever moves toward the synchronized input
  a_r2_follow_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(sync_i)));

  // R2: the filtered level holds while the input agrees with it
  a_r2_hold_when_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i == lvl_q) |=> $stable(lvl_q));
endmodule

// File: rtl/rise_pulse.sv
`timescale 1ns/1ps
module rise_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic pulse_o
);
  logic lvl_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d_q <= 1'b0;
    else         lvl_d_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~lvl_d_q;

  a_r3_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  a_r5_no_release_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i && $past(lvl_i)) |-> !pulse_o);
endmodule

// File: rtl/soft_repeat.sv
`timescale 1ns/1ps
module soft_repeat #(
  parameter int unsigned DELAY    = 15000000,
  parameter int unsigned INTERVAL = 4000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic held_i,
  input  logic gate_i,
  output logic rpt_o
);
  localparam int unsigned MAXC = (DELAY > INTERVAL) ? DELAY : INTERVAL;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;  // first repeat already given
  logic          rpt_q;
  logic [CW-1:0] limit;

  assign limit = armed_q ? CW'(INTERVAL - 1) : CW'(DELAY - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      rpt_q   <= 1'b0;
    end else if (!held_i || gate_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      rpt_q   <= 1'b0;
    end else if (cnt_q == limit) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      rpt_q   <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      rpt_q <= 1'b0;
    end
  end

  assign rpt_o = rpt_q;

  a_r6_gate_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i |=> !rpt_o);

  a_r4_repeat_needs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_o |-> $past(held_i));

  // R4: repeats are spaced, never back to back (INTERVAL >= 2)
  a_r4_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_o |=> !rpt_o);
endmodule

// File: rtl/game_btn_cond.sv
`timescale 1ns/1ps
module game_btn_cond
  import game_btn_pkg::*;
#(
  parameter int unsigned DEB_CYCLES   = 50000,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RPT_DELAY    = 15000000,
  parameter int unsigned RPT_INTERVAL = 4000000,
  parameter bit          SOFT_ONBOARD = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic left_i,
  input  logic right_i,
  input  logic soft_i,
  input  logic hard_i,
  input  logic pause_i,
  input  logic rotate_i,
  input  logic hold_i,
  input  logic pause_board_i,
  input  logic soft_board_i,
  input  logic nav_gate_i,
  output logic left_o,
  output logic right_o,
  output logic soft_o,
  output logic hard_o,
  output logic pause_o,
  output logic rotate_o,
  output logic hold_o,
  output logic soft_held_o
);
  logic [N_RAW-1:0] raw_w, sync_w, deb_w;
  logic [N_ACT-1:0] act_lvl, rise_w, pulse_w;
  logic             rpt_w;

  assign raw_w = {soft_board_i, pause_board_i, hold_i, rotate_i,
                  pause_i, hard_i, soft_i, right_i, left_i};

  for (genvar g = 0; g < N_RAW; g++) begin : g_raw
    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_w[g]),
      .q_o   (sync_w[g])
    );
    btn_debounce #(.CYCLES(DEB_CYCLES)) u_deb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sync_i(sync_w[g]),
      .lvl_o (deb_w[g])
    );
  end

  always_comb begin
    act_lvl           = deb_w[N_ACT-1:0];
    act_lvl[CH_PAUSE] = deb_w[CH_PAUSE] | deb_w[RAW_PAUSE_BOARD];
    act_lvl[CH_SOFT]  = SOFT_ONBOARD ? deb_w[RAW_SOFT_BOARD] : deb_w[CH_SOFT];
  end

  for (genvar g = 0; g < N_ACT; g++) begin : g_act
    rise_pulse u_rise (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (act_lvl[g]),
      .pulse_o(rise_w[g])
    );
  end

  soft_repeat #(.DELAY(RPT_DELAY), .INTERVAL(RPT_INTERVAL)) u_rpt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .held_i(act_lvl[CH_SOFT]),
    .gate_i(nav_gate_i),
    .rpt_o (rpt_w)
  );

  always_comb begin
    pulse_w          = rise_w;
    pulse_w[CH_SOFT] = rise_w[CH_SOFT] | rpt_w;
  end

  assign left_o      = pulse_w[CH_LEFT];
  assign right_o     = pulse_w[CH_RIGHT];
  assign soft_o      = pulse_w[CH_SOFT];
  assign hard_o      = pulse_w[CH_HARD];
  assign pause_o     = pulse_w[CH_PAUSE];
  assign rotate_o    = pulse_w[CH_ROTATE];
  assign hold_o      = pulse_w[CH_HOLD];
  assign soft_held_o = act_lvl[CH_SOFT];

  a_r7_pause_either: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> (deb_w[CH_PAUSE] || deb_w[RAW_PAUSE_BOARD]));

  // R4: non-soft actions only pulse on a fresh rise of their filtered level
  a_r4_no_repeat_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_o |-> !$past(deb_w[CH_LEFT]));
endmodule

// File: tb/sim_game_btn_cond.sv
`timescale 1ns/1ps
module sim_game_btn_cond;
  localparam int DEB = 8;
  localparam int DLY = 40;
  localparam int IVL = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] raw = '0;
  logic gate = 1'b0;
  logic [6:0] outs;
  logic held;
  int pc [7];
  int base [7];
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  game_btn_cond #(
    .DEB_CYCLES(DEB), .SYNC_STAGES(2), .RPT_DELAY(DLY),
    .RPT_INTERVAL(IVL), .SOFT_ONBOARD(1'b0)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .left_i(raw[0]), .right_i(raw[1]), .soft_i(raw[2]), .hard_i(raw[3]),
    .pause_i(raw[4]), .rotate_i(raw[5]), .hold_i(raw[6]),
    .pause_board_i(raw[7]), .soft_board_i(raw[8]), .nav_gate_i(gate),
    .left_o(outs[0]), .right_o(outs[1]), .soft_o(outs[2]), .hard_o(outs[3]),
    .pause_o(outs[4]), .rotate_o(outs[5]), .hold_o(outs[6]),
    .soft_held_o(held)
  );

  initial for (int i = 0; i < 7; i++) pc[i] = 0;

  always @(negedge clk) begin
    if (rst_n) for (int i = 0; i < 7; i++) if (outs[i]) pc[i] = pc[i] + 1;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    for (int i = 0; i < 7; i++) base[i] = pc[i];
  endtask

  // expected pulse counts: only channel ch sees n pulses
  task automatic expect_only(input int ch, input int n, input string tag);
    for (int i = 0; i < 7; i++) begin
      int d;
      d = pc[i] - base[i];
      check(d == ((i == ch) ? n : 0), tag, d, (i == ch) ? n : 0);
    end
  endtask

  task automatic press(input int idx, input int bin, input int hold, input int bout);
    for (int b = 0; b < bin; b++) begin
      raw[idx] = 1'b1; idle(1 + b % 3);
      raw[idx] = 1'b0; idle(2);
    end
    raw[idx] = 1'b1;
    idle(hold);
    raw[idx] = 1'b0;
    for (int b = 0; b < bout; b++) begin
      idle(2);
      raw[idx] = 1'b1; idle(1 + b % 2);
      raw[idx] = 1'b0;
    end
    idle(3 * DEB + 6);
  endtask

  task automatic t_reset();
    check(outs == 7'd0, "R9 outputs zero in reset", int'(outs), 0);
    check(held == 1'b0, "R9 soft_held zero in reset", int'(held), 0);
  endtask

  task automatic t_bouncy_press();
    snap();
    press(0, 4, 30, 4);
    expect_only(0, 1, "R3 bouncy left press gives one pulse");
  endtask

  task automatic t_each_button();
    int map [7] = '{0, 1, 2, 3, 4, 5, 6};
    for (int c = 0; c < 7; c++) begin
      snap();
      press(map[c], 2, 25, 2);
      expect_only(c, 1, "R1 button maps to own output");
    end
  endtask

  task automatic t_glitch();
    snap();
    raw[5] = 1'b1; idle(DEB - 3); raw[5] = 1'b0;
    idle(3 * DEB);
    expect_only(5, 0, "R2 short glitch ignored");
  endtask

  task automatic t_repress();
    snap();
    press(3, 0, 25, 0);
    check(pc[3] - base[3] == 1, "R5 release gives no pulse", pc[3] - base[3], 1);
    press(3, 2, 25, 2);
    expect_only(3, 2, "R5 second press gives new pulse");
  endtask

  task automatic t_pause_board();
    snap();
    press(7, 3, 25, 3);
    expect_only(4, 1, "R7 onboard pause drives pause_o");
    snap();
    press(4, 0, 25, 0);
    expect_only(4, 1, "R7 external pause drives pause_o");
  endtask

  task automatic t_soft_repeat();
    snap();
    raw[2] = 1'b1;
    idle(30);
    check(held == 1'b1, "R8 soft_held high while held", int'(held), 1);
    idle(45);
    raw[2] = 1'b0;
    idle(3 * DEB + 6);
    check(held == 1'b0, "R8 soft_held low after release", int'(held), 0);
    expect_only(2, 5, "R4 soft repeat count over 75-cycle hold");
  endtask

  task automatic t_gate();
    gate = 1'b1;
    snap();
    press(2, 0, 75, 0);
    expect_only(2, 1, "R6 gate blocks repeat, press still pulses");
    gate = 1'b0;
  endtask

  task automatic t_no_repeat_other();
    snap();
    press(0, 0, 120, 0);
    expect_only(0, 1, "R4 long left hold does not repeat");
  endtask

  task automatic t_soft_source();
    snap();
    raw[8] = 1'b1;
    idle(40);
    check(held == 1'b0, "R10 onboard soft ignored (level)", int'(held), 0);
    raw[8] = 1'b0;
    idle(3 * DEB);
    expect_only(2, 0, "R10 onboard soft ignored (pulses)");
  endtask

  task automatic t_reset_mid();
    raw[2] = 1'b1;
    idle(25);
    check(held == 1'b1, "R9 soft held before reset", int'(held), 1);
    rst_n = 1'b0;
    #1;
    check(held == 1'b0 && outs == 7'd0, "R9 async reset clears outputs", int'(held), 0);
    raw[2] = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3 * DEB);
  endtask

  initial begin
    idle(5);
    t_reset();
    rst_n = 1'b1;
    idle(3);
    t_bouncy_press();
    t_each_button();
    t_glitch();
    t_repress();
    t_pause_board();
    t_soft_repeat();
    t_gate();
    t_no_repeat_other();
    t_soft_source();
    t_reset_mid();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule